// File: doc/BRIEF.md
# Privileged Trap Entry and Return Unit

This unit decides, cycle by cycle, whether a small 32-bit core with Machine (M), Supervisor (S) and User (U) privilege must leave its normal instruction stream. It takes synchronous exception requests, four pending interrupt lines, the current PC and privilege level, and the return strobes for M-level and S-level returns. It owns the trap control registers for both privilege levels. When a trap or a return is due, it raises a redirect together with the new PC and the new privilege level in the same cycle. All register side effects of that event commit at the next clock edge.

Traps are routed to M or S through two delegation masks, one for exceptions and one for interrupts. The target address comes from the chosen level's vector register, either as a single entry point or, for interrupts, as a table indexed by cause. The status register's enable, previous-enable and previous-privilege fields are saved on entry and restored on return as one step. Software reaches every register through a single-cycle CSR port with combinational reads.

Top module: `hart_trap_unit`

## Requirements
- R1: After reset every trap register reads 0, no redirect is raised while no event is pending, and privilege encodings are U=00, S=01, M=11.
- R2: On trap entry the interrupted PC goes to the target level's EPC register (0x341 for M, 0x141 for S). The cause goes to its cause register (0x342 / 0x142). The fault value goes to its tval register (0x343 / 0x143) for an exception, and 0 is written there for an interrupt.
- R3: The status register is 0x300, with SIE at bit 1, MIE at bit 3, SPIE at bit 5, MPIE at bit 7, SPP at bit 8 and MPP at bits 12:11. Its S view is 0x100 (bits 1, 5 and 8). An M entry sets MPIE to the old MIE, clears MIE and sets MPP to the old privilege. An S entry does the same with SPIE, SIE and SPP, where SPP is 1 if the old privilege was S.
- R4: Vector registers are 0x305 (M) and 0x105 (S). Bit 0 selects vectored mode, and bit 1 always reads 0. The target is the base with bits 1:0 cleared. In vectored mode only, an interrupt adds cause×4 to that base.
- R5: An M return (when no trap is taken) redirects to the M EPC with privilege MPP, sets MIE to MPIE, sets MPIE to 1 and sets MPP to U.
- R6: Cause bit 31 is 1 for an interrupt and 0 for an exception. Interrupt codes are 11 for M external, 3 for M software, 7 for M timer, 9 for S external, 1 for S software and 5 for S timer.
- R7: An interrupt not delegated to S is taken only if its pending bit (0x344) and its enable bit (0x304) are both set. When the hart runs in M, MIE must also be set.
- R8: Exceptions win over interrupts. Among interrupts the order is 11, 3, 7, 9, 1, 5.
- R9: Bit n of the exception delegation register (0x302) sends exception cause n to S, unless the hart runs in M, in which case the exception goes to M.
- R10: An S return (when no trap is taken and no M return is requested) redirects to the S EPC with privilege {0,SPP}, sets SIE to SPIE, sets SPIE to 1 and clears SPP.
- R11: The interrupt delegation register (0x303) holds only bits 1, 5 and 9. A delegated interrupt is never taken in M. It is taken in U, or in S with SIE set.
- R12: A trap wins over a return, and an M return wins over an S return. A CSR write in a redirect cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| excValid | input | 1 | Exception request this cycle |
| excCause | input | 5 | Exception cause code |
| excTval | input | 32 | Exception fault value |
| irqMext | input | 1 | M external interrupt pending |
| irqMtimer | input | 1 | M timer interrupt pending |
| irqSext | input | 1 | S external interrupt pending |
| irqStimer | input | 1 | S timer interrupt pending |
| pc | input | 32 | PC of the instruction in the trap slot |
| curPriv | input | 2 | Current privilege level |
| mretValid | input | 1 | M-level return retiring |
| sretValid | input | 1 | S-level return retiring |
| csrWe | input | 1 | CSR write strobe |
| csrAddr | input | 12 | CSR address |
| csrWdata | input | 32 | CSR write data |
| csrRdata | output | 32 | CSR read data (combinational) |
| redirectValid | output | 1 | Redirect the fetch this cycle |
| redirectPc | output | 32 | Redirect target |
| newPriv | output | 2 | Privilege level after the redirect |

## Verification
Directed sequences drive exceptions and interrupts at each privilege level, with delegation on and off and with the enable bits set and cleared. This separates the routing decision from the masking decision. Overlapping events, such as an exception together with pending interrupts or a CSR write in a trap cycle, expose the arbitration order. Random vector bases, modes, exception causes and interrupt subsets check the target arithmetic and the priority encoder against bench functions. In this random part, exceptions show that vectored mode leaves their target at the base.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int CODE_W = 5;
  localparam int IRQ_N  = 12;

  localparam logic [1:0] PRIV_U = 2'b00;
  localparam logic [1:0] PRIV_S = 2'b01;
  localparam logic [1:0] PRIV_M = 2'b11;

  localparam int IRQ_SSI = 1;
  localparam int IRQ_MSI = 3;
  localparam int IRQ_STI = 5;
  localparam int IRQ_MTI = 7;
  localparam int IRQ_SEI = 9;
  localparam int IRQ_MEI = 11;

  localparam logic [11:0] A_MSTATUS = 12'h300;
  localparam logic [11:0] A_MEDELEG = 12'h302;
  localparam logic [11:0] A_MIDELEG = 12'h303;
  localparam logic [11:0] A_MIE     = 12'h304;
  localparam logic [11:0] A_MTVEC   = 12'h305;
  localparam logic [11:0] A_MEPC    = 12'h341;
  localparam logic [11:0] A_MCAUSE  = 12'h342;
  localparam logic [11:0] A_MTVAL   = 12'h343;
  localparam logic [11:0] A_MIP     = 12'h344;
  localparam logic [11:0] A_SSTATUS = 12'h100;
  localparam logic [11:0] A_SIE     = 12'h104;
  localparam logic [11:0] A_STVEC   = 12'h105;
  localparam logic [11:0] A_SEPC    = 12'h141;
  localparam logic [11:0] A_SCAUSE  = 12'h142;
  localparam logic [11:0] A_STVAL   = 12'h143;
  localparam logic [11:0] A_SIP     = 12'h144;

  // strobes from the decision logic to the register datapath
  typedef struct packed {
    logic              toM;
    logic              toS;
    logic              isIrq;
    logic [CODE_W-1:0] code;
    logic              doMret;
    logic              doSret;
    logic              csrWr;
  } trap_strobe_t;
endpackage

// File: rtl/trap_decide.sv
module trap_decide
  import trap_pkg::*;
#(
  parameter int EXC_N = 16
) (
  input  logic              excValid,
  input  logic [CODE_W-1:0] excCause,
  input  logic [1:0]        curPriv,
  input  logic              mretValid,
  input  logic              sretValid,
  input  logic              csrWe,
  input  logic              gMie,
  input  logic              gSie,
  input  logic [IRQ_N-1:0]  pendEn,
  input  logic [IRQ_N-1:0]  midelegQ,
  input  logic [EXC_N-1:0]  medelegQ,
  output trap_strobe_t      strobe
);
  localparam int NO_RANK = 6;

  function automatic int rankOf(input int code);
    case (code)
      IRQ_MEI: rankOf = 0;
      IRQ_MSI: rankOf = 1;
      IRQ_MTI: rankOf = 2;
      IRQ_SEI: rankOf = 3;
      IRQ_SSI: rankOf = 4;
      IRQ_STI: rankOf = 5;
      default: rankOf = NO_RANK;
    endcase
  endfunction

  logic mGate, sGate;
  logic [IRQ_N-1:0] mTake, sTake, cand;
  logic irqHit, irqToS, excDeleg, trapNow, routeS;
  logic [CODE_W-1:0] irqCode;
  int best;

  assign mGate = (curPriv != PRIV_M) || gMie;
  assign sGate = (curPriv == PRIV_U) || ((curPriv == PRIV_S) && gSie);
  assign mTake = pendEn & ~midelegQ & {IRQ_N{mGate}};
  assign sTake = pendEn & midelegQ & {IRQ_N{sGate}};
  assign cand  = mTake | sTake;

  always_comb begin
    best    = NO_RANK;
    irqHit  = 1'b0;
    irqToS  = 1'b0;
    irqCode = '0;
    for (int k = 0; k < IRQ_N; k++) begin
      if (cand[k] && (rankOf(k) < best)) begin
        best    = rankOf(k);
        irqHit  = 1'b1;
        irqCode = CODE_W'(k);
        irqToS  = sTake[k];
      end
    end
  end

  always_comb begin
    excDeleg = 1'b0;
    for (int k = 0; k < EXC_N; k++) begin
      if (excCause == CODE_W'(k)) excDeleg = medelegQ[k];
    end
  end

  assign trapNow = excValid | irqHit;
  assign routeS  = excValid ? (excDeleg && (curPriv != PRIV_M)) : irqToS;

  always_comb begin
    strobe.toM    = trapNow & ~routeS;
    strobe.toS    = trapNow & routeS;
    strobe.isIrq  = ~excValid & irqHit;
    strobe.code   = excValid ? excCause : irqCode;
    strobe.doMret = ~trapNow & mretValid;
    strobe.doSret = ~trapNow & ~mretValid & sretValid;
    strobe.csrWr  = csrWe & ~trapNow & ~mretValid & ~sretValid;
  end
endmodule

// File: rtl/trap_csr_dp.sv
module trap_csr_dp
  import trap_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int EXC_N = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  trap_strobe_t     strobe,
  input  logic [XLEN-1:0]  pc,
  input  logic [XLEN-1:0]  excTval,
  input  logic [1:0]       curPriv,
  input  logic             irqMext,
  input  logic             irqMtimer,
  input  logic             irqSext,
  input  logic             irqStimer,
  input  logic [11:0]      csrAddr,
  input  logic [XLEN-1:0]  csrWdata,
  output logic [XLEN-1:0]  csrRdata,
  output logic             redirectValid,
  output logic [XLEN-1:0]  redirectPc,
  output logic [1:0]       newPriv,
  output logic             gMie,
  output logic             gSie,
  output logic [IRQ_N-1:0] pendEn,
  output logic [IRQ_N-1:0] midelegQ,
  output logic [EXC_N-1:0] medelegQ
);
  localparam logic [IRQ_N-1:0] IRQ_IMPL   = 12'hAAA;
  localparam logic [IRQ_N-1:0] IRQ_DELEGS = 12'h222;
  localparam logic [EXC_N-1:0] EXC_DELEGS = ~(EXC_N'(1) << 11);
  localparam logic [XLEN-1:0]  S_VIEW     = XLEN'(32'h122);

  logic mieQ, sieQ, mpieQ, spieQ, sppQ, msipQ, ssipQ;
  logic [1:0] mppQ;
  logic [IRQ_N-1:0] irqEnQ, ipVec;
  logic [XLEN-1:0] mtvecQ, stvecQ, mepcQ, sepcQ, mcauseQ, scauseQ, mtvalQ, stvalQ;
  logic [XLEN-1:0] statusV, causeV, tvecSel, vecBase, trapPc, tvalV;
  logic enter;

  always_comb begin
    ipVec          = '0;
    ipVec[IRQ_MEI] = irqMext;
    ipVec[IRQ_MTI] = irqMtimer;
    ipVec[IRQ_SEI] = irqSext;
    ipVec[IRQ_STI] = irqStimer;
    ipVec[IRQ_MSI] = msipQ;
    ipVec[IRQ_SSI] = ssipQ;
  end
  assign pendEn = ipVec & irqEnQ;
  assign gMie   = mieQ;
  assign gSie   = sieQ;

  always_comb begin
    statusV        = '0;
    statusV[1]     = sieQ;
    statusV[3]     = mieQ;
    statusV[5]     = spieQ;
    statusV[7]     = mpieQ;
    statusV[8]     = sppQ;
    statusV[12:11] = mppQ;
  end

  always_comb begin
    causeV                 = '0;
    causeV[XLEN-1]         = strobe.isIrq;
    causeV[CODE_W-1:0]     = strobe.code;
  end

  // target vector
  assign enter   = strobe.toM | strobe.toS;
  assign tvecSel = strobe.toS ? stvecQ : mtvecQ;
  assign vecBase = {tvecSel[XLEN-1:2], 2'b00};
  assign trapPc  = (tvecSel[0] && strobe.isIrq) ? vecBase + (XLEN'(strobe.code) << 2) : vecBase;
  assign tvalV   = strobe.isIrq ? '0 : excTval;

  assign redirectValid = enter | strobe.doMret | strobe.doSret;
  always_comb begin
    if (enter)              redirectPc = trapPc;
    else if (strobe.doMret) redirectPc = mepcQ;
    else                    redirectPc = sepcQ;
  end
  always_comb begin
    if (strobe.toM)         newPriv = PRIV_M;
    else if (strobe.toS)    newPriv = PRIV_S;
    else if (strobe.doMret) newPriv = mppQ;
    else if (strobe.doSret) newPriv = {1'b0, sppQ};
    else                    newPriv = curPriv;
  end

  always_comb begin
    case (csrAddr)
      A_MSTATUS: csrRdata = statusV;
      A_SSTATUS: csrRdata = statusV & S_VIEW;
      A_MIE:     csrRdata = XLEN'(irqEnQ);
      A_SIE:     csrRdata = XLEN'(irqEnQ & midelegQ);
      A_MIP:     csrRdata = XLEN'(ipVec);
      A_SIP:     csrRdata = XLEN'(ipVec & midelegQ);
      A_MTVEC:   csrRdata = mtvecQ;
      A_STVEC:   csrRdata = stvecQ;
      A_MEPC:    csrRdata = mepcQ;
      A_SEPC:    csrRdata = sepcQ;
      A_MCAUSE:  csrRdata = mcauseQ;
      A_SCAUSE:  csrRdata = scauseQ;
      A_MTVAL:   csrRdata = mtvalQ;
      A_STVAL:   csrRdata = stvalQ;
      A_MIDELEG: csrRdata = XLEN'(midelegQ);
      A_MEDELEG: csrRdata = XLEN'(medelegQ);
      default:   csrRdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      {mieQ, sieQ, mpieQ, spieQ, sppQ, msipQ, ssipQ} <= '0;
      mppQ     <= PRIV_U;
      irqEnQ   <= '0;
      midelegQ <= '0;
      medelegQ <= '0;
      mtvecQ   <= '0;
      stvecQ   <= '0;
      mepcQ    <= '0;
      sepcQ    <= '0;
      mcauseQ  <= '0;
      scauseQ  <= '0;
      mtvalQ   <= '0;
      stvalQ   <= '0;
    end else if (strobe.toM) begin
      mepcQ   <= pc;
      mcauseQ <= causeV;
      mtvalQ  <= tvalV;
      mpieQ   <= mieQ;
      mieQ    <= 1'b0;
      mppQ    <= curPriv;
    end else if (strobe.toS) begin
      sepcQ   <= pc;
      scauseQ <= causeV;
      stvalQ  <= tvalV;
      spieQ   <= sieQ;
      sieQ    <= 1'b0;
      sppQ    <= (curPriv == PRIV_S);
    end else if (strobe.doMret) begin
      mieQ  <= mpieQ;
      mpieQ <= 1'b1;
      mppQ  <= PRIV_U;
    end else if (strobe.doSret) begin
      sieQ  <= spieQ;
      spieQ <= 1'b1;
      sppQ  <= 1'b0;
    end else if (strobe.csrWr) begin
      case (csrAddr)
        A_MSTATUS: begin
          sieQ  <= csrWdata[1];
          mieQ  <= csrWdata[3];
          spieQ <= csrWdata[5];
          mpieQ <= csrWdata[7];
          sppQ  <= csrWdata[8];
          mppQ  <= (csrWdata[12:11] == 2'b10) ? PRIV_U : csrWdata[12:11];
        end
        A_SSTATUS: begin
          sieQ  <= csrWdata[1];
          spieQ <= csrWdata[5];
          sppQ  <= csrWdata[8];
        end
        A_MIE:     irqEnQ <= csrWdata[IRQ_N-1:0] & IRQ_IMPL;
        A_SIE:     irqEnQ <= (irqEnQ & ~midelegQ) | (csrWdata[IRQ_N-1:0] & midelegQ);
        A_MIP: begin
          msipQ <= csrWdata[IRQ_MSI];
          ssipQ <= csrWdata[IRQ_SSI];
        end
        A_SIP:     if (midelegQ[IRQ_SSI]) ssipQ <= csrWdata[IRQ_SSI];
        A_MTVEC:   mtvecQ <= {csrWdata[XLEN-1:2], 1'b0, csrWdata[0]};
        A_STVEC:   stvecQ <= {csrWdata[XLEN-1:2], 1'b0, csrWdata[0]};
        A_MEPC:    mepcQ <= csrWdata;
        A_SEPC:    sepcQ <= csrWdata;
        A_MCAUSE:  mcauseQ <= csrWdata;
        A_SCAUSE:  scauseQ <= csrWdata;
        A_MTVAL:   mtvalQ <= csrWdata;
        A_STVAL:   stvalQ <= csrWdata;
        A_MIDELEG: midelegQ <= csrWdata[IRQ_N-1:0] & IRQ_DELEGS;
        A_MEDELEG: medelegQ <= csrWdata[EXC_N-1:0] & EXC_DELEGS;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/hart_trap_unit.sv
module hart_trap_unit
  import trap_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int EXC_N = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              excValid,
  input  logic [CODE_W-1:0] excCause,
  input  logic [XLEN-1:0]   excTval,
  input  logic              irqMext,
  input  logic              irqMtimer,
  input  logic              irqSext,
  input  logic              irqStimer,
  input  logic [XLEN-1:0]   pc,
  input  logic [1:0]        curPriv,
  input  logic              mretValid,
  input  logic              sretValid,
  input  logic              csrWe,
  input  logic [11:0]       csrAddr,
  input  logic [XLEN-1:0]   csrWdata,
  output logic [XLEN-1:0]   csrRdata,
  output logic              redirectValid,
  output logic [XLEN-1:0]   redirectPc,
  output logic [1:0]        newPriv
);
  trap_strobe_t     strobe;
  logic             gMie, gSie;
  logic [IRQ_N-1:0] pendEn, midelegQ;
  logic [EXC_N-1:0] medelegQ;

  trap_decide #(.EXC_N(EXC_N)) i_decide (
    .excValid(excValid), .excCause(excCause), .curPriv(curPriv),
    .mretValid(mretValid), .sretValid(sretValid), .csrWe(csrWe),
    .gMie(gMie), .gSie(gSie), .pendEn(pendEn),
    .midelegQ(midelegQ), .medelegQ(medelegQ), .strobe(strobe)
  );

  trap_csr_dp #(.XLEN(XLEN), .EXC_N(EXC_N)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pc(pc), .excTval(excTval),
    .curPriv(curPriv), .irqMext(irqMext), .irqMtimer(irqMtimer),
    .irqSext(irqSext), .irqStimer(irqStimer), .csrAddr(csrAddr),
    .csrWdata(csrWdata), .csrRdata(csrRdata), .redirectValid(redirectValid),
    .redirectPc(redirectPc), .newPriv(newPriv), .gMie(gMie), .gSie(gSie),
    .pendEn(pendEn), .midelegQ(midelegQ), .medelegQ(medelegQ)
  );
endmodule

// File: rtl/hart_trap_unit_chk.sv
module hart_trap_unit_chk
  import trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            excValid,
  input logic            mretValid,
  input logic            sretValid,
  input logic [1:0]      curPriv,
  input logic            redirectValid,
  input logic [XLEN-1:0] redirectPc,
  input logic [1:0]      newPriv,
  input trap_strobe_t    strobe,
  input logic            gMie
);
  assert_exc_redirect_R8: assert property (@(posedge clk) disable iff (!rstN)
    excValid |-> (redirectValid && !strobe.isIrq));

  assert_one_action_R12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.toM, strobe.toS, strobe.doMret, strobe.doSret}));

  assert_m_keeps_m_R9: assert property (@(posedge clk) disable iff (!rstN)
    (curPriv == PRIV_M && redirectValid && !mretValid && !sretValid) |-> (newPriv == PRIV_M));

  assert_m_masked_R7: assert property (@(posedge clk) disable iff (!rstN)
    (curPriv == PRIV_M && !gMie && !excValid && !mretValid && !sretValid) |-> !redirectValid);

  assert_entry_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.toM |=> !gMie);

  assert_target_aligned_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.toM || strobe.toS) |-> (redirectPc[1:0] == 2'b00));
endmodule

bind hart_trap_unit hart_trap_unit_chk #(.XLEN(XLEN)) i_chk (
  .clk(clk), .rstN(rstN), .excValid(excValid), .mretValid(mretValid),
  .sretValid(sretValid), .curPriv(curPriv), .redirectValid(redirectValid),
  .redirectPc(redirectPc), .newPriv(newPriv), .strobe(strobe), .gMie(gMie)
);

// File: tb/test_hart_trap_unit.sv
module test_hart_trap_unit;
  import trap_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic excValid = 1'b0;
  logic [4:0] excCause = '0;
  logic [31:0] excTval = '0;
  logic irqMext = 1'b0, irqMtimer = 1'b0, irqSext = 1'b0, irqStimer = 1'b0;
  logic [31:0] pc = '0;
  logic [1:0] priv = PRIV_M;
  logic mretValid = 1'b0, sretValid = 1'b0, csrWe = 1'b0;
  logic [11:0] csrAddr = '0;
  logic [31:0] csrWdata = '0;
  logic [31:0] csrRdata, redirectPc;
  logic redirectValid;
  logic [1:0] newPriv;

  int errors = 0;
  int checks = 0;
  logic gotRv;
  logic [31:0] gotPc;
  logic [1:0] gotPriv;

  always #5 clk = ~clk;

  hart_trap_unit i_hart_trap_unit (
    .clk(clk), .rstN(rstN), .excValid(excValid), .excCause(excCause),
    .excTval(excTval), .irqMext(irqMext), .irqMtimer(irqMtimer),
    .irqSext(irqSext), .irqStimer(irqStimer), .pc(pc), .curPriv(priv),
    .mretValid(mretValid), .sretValid(sretValid), .csrWe(csrWe),
    .csrAddr(csrAddr), .csrWdata(csrWdata), .csrRdata(csrRdata),
    .redirectValid(redirectValid), .redirectPc(redirectPc), .newPriv(newPriv)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] expTarget(input logic [31:0] tvec, input logic irq, input int code);
    logic [31:0] base = {tvec[31:2], 2'b00};
    if (tvec[0] && irq) return base + 32'(code) * 4;
    return base;
  endfunction

  // fixed interrupt order: 11, 3, 7, 9, 1, 5
  function automatic int expWinner(input logic [11:0] pend);
    int order [6] = '{11, 3, 7, 9, 1, 5};
    for (int k = 0; k < 6; k++) if (pend[order[k]]) return order[k];
    return -1;
  endfunction

  // all tasks start just after a falling edge
  task automatic csrWrite(input logic [11:0] a, input logic [31:0] d);
    csrWe = 1'b1; csrAddr = a; csrWdata = d;
    @(negedge clk);
    csrWe = 1'b0;
  endtask

  task automatic csrRead(input logic [11:0] a, output logic [31:0] d);
    csrAddr = a;
    #1 d = csrRdata;
  endtask

  task automatic fire(input logic e, input logic [4:0] c, input logic [31:0] tv,
                      input logic [31:0] p, input logic mr, input logic sr);
    excValid = e; excCause = c; excTval = tv; pc = p; mretValid = mr; sretValid = sr;
    #1;
    gotRv = redirectValid; gotPc = redirectPc; gotPriv = newPriv;
    @(negedge clk);
    excValid = 1'b0; mretValid = 1'b0; sretValid = 1'b0;
    if (gotRv) priv = gotPriv;
  endtask

  task automatic expectCsr(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    csrRead(a, v);
    check(tag, v, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] tv;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    expectCsr("R1 mstatus", A_MSTATUS, 32'h0);
    expectCsr("R1 mtvec", A_MTVEC, 32'h0);
    expectCsr("R1 mcause", A_MCAUSE, 32'h0);
    fire(0, 0, 0, 32'h0, 0, 0);
    check("R1 idle no redirect", 32'(gotRv), 32'h0);

    // R2 R3 exception into M, direct mode
    csrWrite(A_MTVEC, 32'h100);
    csrWrite(A_MSTATUS, 32'h8);
    fire(1, 5'd2, 32'hDEAD, 32'h1000, 0, 0);
    check("R2 redirect", 32'(gotRv), 32'h1);
    check("R4 direct target", gotPc, 32'h100);
    check("R2 new priv M", 32'(gotPriv), 32'(PRIV_M));
    expectCsr("R2 mepc", A_MEPC, 32'h1000);
    expectCsr("R6 mcause exc", A_MCAUSE, 32'h2);
    expectCsr("R2 mtval", A_MTVAL, 32'hDEAD);
    expectCsr("R3 mstatus on entry", A_MSTATUS, 32'h1880);

    // R5 M return
    fire(0, 0, 0, 32'h0, 1, 0);
    check("R5 mret target", gotPc, 32'h1000);
    check("R5 mret priv", 32'(gotPriv), 32'(PRIV_M));
    expectCsr("R5 mstatus after mret", A_MSTATUS, 32'h88);

    // R4 vectored mode, exceptions use the base
    csrWrite(A_MTVEC, 32'h203);
    expectCsr("R4 mode bit1 reads 0", A_MTVEC, 32'h201);
    fire(1, 5'd5, 32'h0, 32'h1100, 0, 0);
    check("R4 exception ignores vector", gotPc, 32'h200);
    fire(0, 0, 0, 32'h0, 1, 0);

    // R7 masking in M
    csrWrite(A_MSTATUS, 32'h0);
    csrWrite(A_MIE, 32'h800);
    irqMext = 1'b1;
    fire(0, 0, 0, 32'h1200, 0, 0);
    check("R7 masked by MIE in M", 32'(gotRv), 32'h0);
    csrWrite(A_MSTATUS, 32'h8);
    fire(0, 0, 32'h55, 32'h1204, 0, 0);
    check("R7 taken with MIE", 32'(gotRv), 32'h1);
    check("R4 vectored interrupt target", gotPc, 32'h22C);
    expectCsr("R6 mcause MEI", A_MCAUSE, 32'h8000000B);
    expectCsr("R2 mtval zero for irq", A_MTVAL, 32'h0);
    irqMext = 1'b0;

    // R8 priority
    csrWrite(A_MIE, 32'hAAA);
    priv = PRIV_U;
    irqMtimer = 1'b1; irqSext = 1'b1;
    fire(0, 0, 0, 32'h1300, 0, 0);
    check("R8 MTI before SEI", gotPc, 32'h21C);
    priv = PRIV_U;
    irqMext = 1'b1;
    fire(0, 0, 0, 32'h1304, 0, 0);
    check("R8 MEI first", gotPc, 32'h22C);
    priv = PRIV_U;
    fire(1, 5'd3, 32'h9, 32'h1308, 0, 0);
    check("R8 exception wins", gotPc, 32'h200);
    expectCsr("R8 mcause exc", A_MCAUSE, 32'h3);
    irqMext = 1'b0; irqMtimer = 1'b0; irqSext = 1'b0;
    priv = PRIV_M;

    // R9 exception delegation
    csrWrite(A_MEDELEG, 32'hFFFF);
    expectCsr("R9 medeleg bit11 fixed", A_MEDELEG, 32'hF7FF);
    csrWrite(A_MEDELEG, 32'h100);
    csrWrite(A_STVEC, 32'h401);
    csrWrite(A_SSTATUS, 32'h2);
    fire(1, 5'd8, 32'h0, 32'h2000, 0, 0);
    check("R9 not delegated from M", gotPc, 32'h200);
    priv = PRIV_U;
    fire(1, 5'd8, 32'h77, 32'h3000, 0, 0);
    check("R9 delegated target", gotPc, 32'h400);
    check("R9 delegated priv", 32'(gotPriv), 32'(PRIV_S));
    expectCsr("R2 sepc", A_SEPC, 32'h3000);
    expectCsr("R2 scause", A_SCAUSE, 32'h8);
    expectCsr("R2 stval", A_STVAL, 32'h77);
    expectCsr("R3 sstatus on entry", A_SSTATUS, 32'h20);

    // R10 S return
    fire(0, 0, 0, 32'h0, 0, 1);
    check("R10 sret target", gotPc, 32'h3000);
    check("R10 sret priv", 32'(gotPriv), 32'(PRIV_U));
    expectCsr("R10 sstatus after sret", A_SSTATUS, 32'h22);

    // R11 interrupt delegation
    csrWrite(A_MIDELEG, 32'hFFF);
    expectCsr("R11 mideleg mask", A_MIDELEG, 32'h222);
    csrWrite(A_MIE, 32'h200);
    csrWrite(A_SSTATUS, 32'h0);
    irqSext = 1'b1;
    priv = PRIV_M;
    csrWrite(A_MSTATUS, 32'h8);
    fire(0, 0, 0, 32'h4000, 0, 0);
    check("R11 never in M", 32'(gotRv), 32'h0);
    priv = PRIV_S;
    fire(0, 0, 0, 32'h4004, 0, 0);
    check("R11 S needs SIE", 32'(gotRv), 32'h0);
    priv = PRIV_U;
    fire(0, 0, 0, 32'h4008, 0, 0);
    check("R11 taken from U", gotPc, 32'h424);
    expectCsr("R6 scause SEI", A_SCAUSE, 32'h80000009);
    csrWrite(A_SSTATUS, 32'h2);
    fire(0, 0, 0, 32'h400C, 0, 0);
    check("R11 taken in S with SIE", 32'(gotRv), 32'h1);
    expectCsr("R3 SPP set from S", A_SSTATUS, 32'h120);
    irqSext = 1'b0;

    // R12 CSR write dropped in trap cycle
    priv = PRIV_M;
    csrWe = 1'b1; csrAddr = A_MTVEC; csrWdata = 32'h900;
    fire(1, 5'd2, 32'h0, 32'h5000, 0, 0);
    csrWe = 1'b0;
    check("R12 trap wins", gotPc, 32'h200);
    expectCsr("R12 write ignored", A_MTVEC, 32'h201);
    fire(1, 5'd4, 32'h0, 32'h5004, 1, 1);
    check("R12 trap over returns", gotPc, 32'h200);

    // random part: M routing, vector arithmetic, priority
    csrWrite(A_MIDELEG, 32'h0);
    csrWrite(A_MEDELEG, 32'h0);
    csrWrite(A_MIE, 32'hAAA);
    for (int i = 0; i < 150; i++) begin
      logic [3:0] lines;
      logic isExc;
      logic [4:0] c;
      logic [31:0] p;
      logic [11:0] pend;
      int code;
      tv = $urandom & 32'hFFFFFFFC;
      tv[0] = $urandom % 2;
      csrWrite(A_MTVEC, tv);
      priv = PRIV_U;
      isExc = ($urandom % 3) == 0;
      c = 5'($urandom % 16);
      p = $urandom & 32'hFFFFFFFC;
      lines = 4'($urandom % 15 + 1);
      pend = '0;
      pend[11] = lines[0]; pend[7] = lines[1]; pend[9] = lines[2]; pend[5] = lines[3];
      if (!isExc) begin
        irqMext = lines[0]; irqMtimer = lines[1]; irqSext = lines[2]; irqStimer = lines[3];
      end
      code = isExc ? int'(c) : expWinner(pend);
      fire(isExc, c, 32'h0, p, 0, 0);
      irqMext = 1'b0; irqMtimer = 1'b0; irqSext = 1'b0; irqStimer = 1'b0;
      check("R4 random target", gotPc, expTarget(tv, !isExc, code));
      expectCsr("R6 random cause", A_MCAUSE, {!isExc, 26'h0, 5'(code)});
      expectCsr("R2 random mepc", A_MEPC, p);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule